// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs one management transaction at a time to an Ethernet PHY over the two-wire MDC/MDIO bus. The host hands over a request: a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then drives a complete frame onto the line through a clock output, a data output and an output-enable for an external tristate pad. When the frame is over, the block returns a one-cycle completion with the read data and an error flag.

Each frame starts with 32 preamble clocks and then a fixed header. A read releases the line for the turnaround and checks that the PHY pulls it low. If the line stays high, the PHY is treated as absent or confused. The block then clocks 32 recovery cycles with the line released and reports an error. Every successful frame ends with one extra released MDC cycle, and MDC rests high between frames.

The request side is valid/ready. `req_ready` is high only while the block is idle. A request is taken on a clock where both `req_valid` and `req_ready` are high, and `req_valid` asserted while the block is busy is ignored. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_rdata` and `rsp_err` keep their values until the next request is accepted. The MDC half-period is `HALF_CYC` system clocks. The default of 20 gives 2.5 MHz from a 100 MHz clock.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1, `mdc` is 1, `mdio_oe` is 0 and `rsp_valid` is 0. A `req_valid` seen while busy starts no transaction and changes neither the frame in flight nor its result.
- R2: Every transaction begins with 32 MDC cycles with `mdio_oe`=1 and `mdio_o`=1.
- R3: After the preamble the block drives the start bits 0 then 1, followed by the opcode: 1,0 for a read (`req_read`=1) and 0,1 for a write.
- R4: After the opcode the block drives the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R5: `mdio_o` and `mdio_oe` change only at the clock where MDC falls or while MDC is low. They are never changed during an MDC high phase.
- R6: On a read, the block releases the line (`mdio_oe`=0) for one turnaround MDC cycle and samples `mdio_i` at the end of that cycle's high phase. A sampled 0 lets the read continue.
- R7: On a successful read, the block samples 16 data bits at the end of each MDC high phase, most significant bit first, with the line released. It then returns them on `rsp_rdata` with `rsp_err`=0.
- R8: If the read turnaround sample is 1, the block clocks 32 further released MDC cycles and then completes with `rsp_err`=1 and `rsp_rdata`=0. An errored read is 79 MDC cycles in all.
- R9: On a write, after the register address the block drives the turnaround bits 1 then 0, and then the 16 data bits most significant bit first, all with `mdio_oe`=1.
- R10: A successful frame ends with one extra MDC cycle with the line released, and MDC stays high afterwards. A read is 64 MDC cycles in total and a write is 65.
- R11: `rsp_valid` is high for exactly one system clock per accepted request.
- R12: Each MDC high and low phase lasts exactly `HALF_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Idle, request can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Turnaround failure on a read |
| rsp_rdata | output | 16 | Read data (0 after a write or an error) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value for the pad |
| mdio_oe | output | 1 | Pad output-enable |
| mdio_i | input | 1 | Data seen on the line |

## Verification
The bench models a PHY that counts MDC rising edges and logs the driven value and the enable in every slot. Against that log it targets the off-by-one corners: a design that samples the turnaround one slot early or late loses the top read bit or shifts the whole word, and a wrong slot count shows up in the total edge count. A missing PHY is modelled by leaving the line high. A design that ignores the turnaround sample returns all-ones data with no error instead of 79 cycles and an error. A request raised mid-frame must leave the frame and its single completion untouched; a design that accepts it would start a second frame or corrupt the header. The bench also measures the MDC phase lengths and watches for data edges during high phases, which catches timers off by one clock and data changed on the rising side.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_SLOTS   = 32;
  localparam int RECOV_SLOTS = 32;
  // start(2) + opcode(2) + phy + reg
  localparam int HDR_BITS    = 4 + 2 * ADDR_W;
  // header + write turnaround(2) + data
  localparam int FRAME_W     = HDR_BITS + 2 + DATA_W;
  localparam int SLOT_CNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_SHIFT,
    S_TA_RD,
    S_DATA_RD,
    S_TAIL,
    S_RECOV
  } mdio_state_t;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= RELOAD;
    else if (!run)      cnt <= RELOAD;
    else if (cnt == '0) cnt <= RELOAD;
    else                cnt <= cnt - 1'b1;
  end

  // R12: a tick never appears while the bus is idle
  assert_tick_needs_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !tick);
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data <= '0;
    else if (clr)      data <= '0;
    else if (shift_en) data <= {data[W-2:0], din};
  end

  // R7: bits enter only on a sampling strobe
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !shift_en |=> $stable(data));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mdio_i,
  output logic              req_ready,
  output logic              run,
  output logic              rx_clr,
  output logic              rx_shift,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  mdio_state_t           st;
  logic [SLOT_CNT_W-1:0] cnt;
  logic [FRAME_W-1:0]    txsr;
  logic                  is_rd;
  logic                  hi;
  logic                  slot_end;
  logic                  accept;

  assign req_ready = (st == S_IDLE);
  assign run       = !req_ready;
  assign accept    = req_ready && req_valid;
  assign rx_clr    = accept;
  assign slot_end  = tick && hi;
  assign rx_shift  = slot_end && (st == S_DATA_RD);
  assign mdio_oe   = (st == S_PRE) || (st == S_SHIFT);
  assign mdio_o    = (st == S_PRE) || ((st == S_SHIFT) && txsr[FRAME_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      txsr      <= '0;
      is_rd     <= 1'b0;
      hi        <= 1'b0;
      mdc       <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        txsr  <= {2'b01, req_read ? 2'b10 : 2'b01, req_phy, req_reg,
                  req_read ? {(DATA_W+2){1'b0}} : {2'b10, req_wdata}};
        is_rd   <= req_read;
        rsp_err <= 1'b0;
        st      <= S_PRE;
        cnt     <= SLOT_CNT_W'(PRE_SLOTS - 1);
        mdc     <= 1'b0;
        hi      <= 1'b0;
      end else if (tick && !hi) begin
        mdc <= 1'b1;
        hi  <= 1'b1;
      end else if (slot_end) begin
        mdc <= 1'b0;
        hi  <= 1'b0;
        unique case (st)
          S_PRE: begin
            if (cnt == '0) begin
              st  <= S_SHIFT;
              cnt <= is_rd ? SLOT_CNT_W'(HDR_BITS - 1) : SLOT_CNT_W'(FRAME_W - 1);
            end else cnt <= cnt - 1'b1;
          end
          S_SHIFT: begin
            txsr <= {txsr[FRAME_W-2:0], 1'b0};
            if (cnt == '0) st <= is_rd ? S_TA_RD : S_TAIL;
            else           cnt <= cnt - 1'b1;
          end
          S_TA_RD: begin
            if (mdio_i) begin
              st  <= S_RECOV;
              cnt <= SLOT_CNT_W'(RECOV_SLOTS - 1);
            end else begin
              st  <= S_DATA_RD;
              cnt <= SLOT_CNT_W'(DATA_W - 1);
            end
          end
          S_DATA_RD: begin
            if (cnt == '0) st <= S_TAIL;
            else           cnt <= cnt - 1'b1;
          end
          S_RECOV: begin
            if (cnt == '0) begin
              st        <= S_IDLE;
              mdc       <= 1'b1;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          S_TAIL: begin
            st        <= S_IDLE;
            mdc       <= 1'b1;
            rsp_valid <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5: line value and enable hold through every MDC high phase
  assert_stable_in_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

  // R12: MDC moves only on a timer tick or on acceptance
  assert_mdc_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !accept |=> $stable(mdc));

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: a frame always finishes with MDC high
  assert_end_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mdc);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic tick, run, rx_clr, rx_shift;

  mdio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_read(req_read), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .mdio_i(mdio_i),
    .req_ready(req_ready), .run(run), .rx_clr(rx_clr), .rx_shift(rx_shift),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_rx_shift #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .shift_en(rx_shift),
    .din(mdio_i), .data(rsp_rdata)
  );

  // R1: idle means clock parked high and pad released
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mdc && !mdio_oe);

  // R8: an errored read carries no data
  assert_err_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);

  // R6: the pad is released whenever the block samples read data
  assert_released_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_shift |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rsp_rdata;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mdio_master #(.HALF_CYC(20)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY model: slot index from MDC rising edges
  int edge_cnt = 0, base = 0;
  logic ta_val = 1'b0;
  logic [15:0] phy_data = '0;
  logic log_o [0:127];
  logic log_oe[0:127];

  always @(posedge mdc) begin
    if (edge_cnt - base >= 0 && edge_cnt - base < 128) begin
      log_o[edge_cnt - base]  = mdio_o;
      log_oe[edge_cnt - base] = mdio_oe;
    end
    edge_cnt = edge_cnt + 1;
  end

  always_comb begin
    int rel;
    rel = edge_cnt - base;
    if (rel == 47)                   mdio_i = ta_val;
    else if (rel >= 48 && rel <= 63) mdio_i = phy_data[63 - rel];
    else                             mdio_i = 1'b1;
  end

  // MDC phase timing
  realtime t_fall = 0, t_rise = 0, last_low = 0, last_high = 0;
  always @(negedge mdc) begin last_high = $realtime - t_rise; t_fall = $realtime; end
  always @(posedge mdc) begin last_low = $realtime - t_fall; t_rise = $realtime; end

  // response and line-stability monitors
  int pulses = 0, hi_viol = 0;
  logic [15:0] got_data;
  logic got_err;
  logic p_mdc = 1'b1, p_o = 1'b0, p_oe = 1'b0;
  always @(negedge clk) begin
    if (rsp_valid) begin
      pulses = pulses + 1;
      got_data = rsp_rdata;
      got_err = rsp_err;
    end
    if (rst_n && mdc && p_mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) hi_viol = hi_viol + 1;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i, input bit rd, input logic [4:0] phy,
                                   input logic [4:0] rg, input logic [15:0] wd);
    if (i < 32) return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return rd;
    if (i == 35) return !rd;
    if (i < 41) return phy[40 - i];
    if (i < 46) return rg[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return wd[63 - i];
  endfunction

  task automatic launch(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd);
    @(negedge clk);
    base = edge_cnt;
    req_valid = 1'b1; req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int p0);
    while (pulses == p0) @(negedge clk);
    repeat (100) @(negedge clk);
  endtask

  task automatic check_header(input string tag, input bit rd, input logic [4:0] phy,
                              input logic [4:0] rg, input logic [15:0] wd);
    int bad_pre, bad_hdr, bad_wr;
    bad_pre = 0; bad_hdr = 0; bad_wr = 0;
    for (int i = 0; i < 32; i++)
      if (log_o[i] !== 1'b1 || log_oe[i] !== 1'b1) bad_pre++;
    for (int i = 32; i < 46; i++)
      if (log_o[i] !== exp_bit(i, rd, phy, rg, wd) || log_oe[i] !== 1'b1) bad_hdr++;
    chk(bad_pre == 0, {tag, " R2 preamble slots"}, bad_pre, 0);
    chk(bad_hdr == 0, {tag, " R3 R4 start/opcode/address slots"}, bad_hdr, 0);
    if (!rd) begin
      for (int i = 46; i < 64; i++)
        if (log_o[i] !== exp_bit(i, rd, phy, rg, wd) || log_oe[i] !== 1'b1) bad_wr++;
      chk(bad_wr == 0, {tag, " R9 turnaround/data slots"}, bad_wr, 0);
      chk(log_oe[64] === 1'b0, {tag, " R10 trailing slot released"}, log_oe[64], 0);
    end
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
    chk(mdc === 1'b1, "R1 reset mdc", mdc, 1);
    chk(mdio_oe === 1'b0, "R1 reset oe", mdio_oe, 0);
    chk(rsp_valid === 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
    int p0, rel_oe;
    p0 = pulses;
    ta_val = 1'b0; phy_data = val;
    launch(1'b1, phy, rg, 16'h0);
    wait_done(p0);
    chk(pulses == p0 + 1, "R11 read one pulse", pulses - p0, 1);
    chk(edge_cnt - base == 64, "R10 read cycle count", edge_cnt - base, 64);
    check_header("read", 1'b1, phy, rg, 16'h0);
    rel_oe = 0;
    for (int i = 46; i < 64; i++) if (log_oe[i] !== 1'b0) rel_oe++;
    chk(rel_oe == 0, "R6 R7 line released from turnaround on", rel_oe, 0);
    chk(got_data == val, "R7 read data", got_data, val);
    chk(got_err == 1'b0, "R7 read no error", got_err, 0);
    chk(mdc === 1'b1 && mdio_oe === 1'b0 && req_ready === 1'b1, "R1 idle after read",
        {mdc, mdio_oe, req_ready}, 3'b101);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
    int p0;
    p0 = pulses;
    launch(1'b0, phy, rg, val);
    wait_done(p0);
    chk(pulses == p0 + 1, "R11 write one pulse", pulses - p0, 1);
    chk(edge_cnt - base == 65, "R10 write cycle count", edge_cnt - base, 65);
    check_header("write", 1'b0, phy, rg, val);
    chk(mdc === 1'b1, "R10 mdc high after write", mdc, 1);
  endtask

  task automatic t_no_phy;
    int p0, rel_oe;
    p0 = pulses;
    ta_val = 1'b1; phy_data = 16'hFFFF;
    launch(1'b1, 5'h1F, 5'h02, 16'h0);
    wait_done(p0);
    chk(pulses == p0 + 1, "R8 error one pulse", pulses - p0, 1);
    chk(edge_cnt - base == 79, "R8 recovery cycle count", edge_cnt - base, 79);
    rel_oe = 0;
    for (int i = 46; i < 79; i++) if (log_oe[i] !== 1'b0) rel_oe++;
    chk(rel_oe == 0, "R8 released during recovery", rel_oe, 0);
    chk(got_err == 1'b1, "R8 error flag", got_err, 1);
    chk(got_data == 16'h0, "R8 no data", got_data, 0);
    ta_val = 1'b0;
  endtask

  task automatic t_busy_ignore;
    int p0, e_end;
    p0 = pulses;
    launch(1'b0, 5'h0A, 5'h15, 16'hC3A5);
    repeat (500) @(negedge clk);
    chk(req_ready === 1'b0, "R1 not ready while busy", req_ready, 0);
    req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h1B; req_reg = 5'h04; req_wdata = 16'h1111;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(p0);
    chk(pulses == p0 + 1, "R1 busy request gives no extra completion", pulses - p0, 1);
    chk(edge_cnt - base == 65, "R1 busy request leaves write length", edge_cnt - base, 65);
    check_header("busy", 1'b0, 5'h0A, 5'h15, 16'hC3A5);
    e_end = edge_cnt;
    repeat (300) @(negedge clk);
    chk(edge_cnt == e_end, "R1 no frame started after ignored request", edge_cnt - e_end, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read(5'h01, 5'h02, 16'hA5C3);
    chk(last_low == 200.0, "R12 low phase", longint'(last_low), 200);
    chk(last_high == 200.0, "R12 high phase", longint'(last_high), 200);
    t_read(5'h10, 5'h1F, 16'h8001);
    t_write(5'h03, 5'h11, 16'h8001);
    t_write(5'h1F, 5'h00, 16'h7FFE);
    t_no_phy();
    t_read(5'h05, 5'h0C, 16'h0000);
    t_busy_ignore();
    chk(hi_viol == 0, "R5 no line change during MDC high", hi_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule